// File: doc/BRIEF.md
# Range-Typed Write-Combining Store Controller

This block stands between a processor's load/store request port and a memory port. It holds two programmable address windows. Each window marks the addresses it covers as uncacheable (UC) or write-combining (WC). An address that falls in neither window is ordinary. Stores to WC space are gathered into one line-sized merge buffer with a valid flag per byte. The buffer is later written out as a single burst that carries a byte-enable mask.

Every other access goes to the memory port as a single cycle at its own address, with nothing allocated. These single cycles are loads of any type, UC stores and ordinary stores. A two-bit ordering control sets when a single cycle must first wait for the merge buffer to drain:
- never;
- only for ordinary cycles;
- always.

The memory port is a plain valid/ready handshake, with a line-wide data path. A request is held until `req_ready`. Load data is returned on `rsp_rdata` in the handshake cycle.

Top module: `wc_range_ctrl`

## Requirements
- R1: After reset, both windows are disabled, so every address is ordinary. The merge buffer is empty and no memory cycle is driven.
- R2: When `cfg_we` is high, window `cfg_sel` is loaded with a base page, a mask page, a type and an enable. The type is `cfg_uc`: 1 means UC and 0 means WC. A request matches an enabled window when ((addr[31:12] ^ base) & mask) == 0. When a UC window and a WC window both match, the address is UC.
- R3: These accesses each produce exactly one memory cycle with `bus_burst`=0, at the request address:
  - a load of any type;
  - a UC store;
  - an ordinary store.
  The byte enables appear in lane addr[4:2], meaning `bus_be` bits 4*lane..4*lane+3. The store data is replicated into every word. Load data is returned from word addr[4:2] of `bus_rdata`. The merge buffer is unchanged.
- R4: A WC store to the line already held, or into an empty buffer, is accepted in the cycle it is presented, with no memory cycle. A later store to a byte that is already valid overwrites that byte.
- R5: A drain is a burst write with `bus_burst`=1 and a line-aligned address (low 5 bits zero). It carries the buffer contents, and `bus_be` equals the per-byte valid flags. The drain is held until `bus_ready`, and it leaves the buffer empty.
- R6: A WC store to a different line first drains the buffer. The store is then merged into the empty buffer.
- R7: A store that makes all 32 bytes valid starts a drain in the next cycle, with no further request.
- R8: `flush_req` in an idle cycle with a non-empty buffer starts a drain, and it takes precedence over a waiting request. With an empty buffer it has no effect.
- R9: With `order_mode[1]`=1, no single cycle waits for the buffer, whatever `order_mode[0]` is.
- R10: With `order_mode`=01, UC and WC single cycles proceed past a non-empty buffer. Ordinary cycles wait for it to drain.
- R11: With `order_mode`=00, every single cycle waits for a non-empty buffer to drain first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_sel | input | 1 | Window index |
| cfg_base_pg | input | 20 | Base page number (addr[31:12]) |
| cfg_mask_pg | input | 20 | Mask page bits |
| cfg_uc | input | 1 | Window type: 1 UC, 0 WC |
| cfg_en | input | 1 | Window enable |
| order_mode | input | 2 | Bit 1: no ordering; bit 0: relaxed ordering |
| flush_req | input | 1 | Request to drain the merge buffer |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_rdata | output | 32 | Load data, valid on a load handshake |
| bus_valid | output | 1 | Memory cycle present |
| bus_write | output | 1 | Memory cycle is a write |
| bus_burst | output | 1 | Memory cycle is a merge-buffer drain |
| bus_addr | output | 32 | Memory address |
| bus_wdata | output | 256 | Memory write data (full line) |
| bus_be | output | 32 | Memory byte enables |
| bus_ready | input | 1 | Memory accepts the cycle |
| bus_rdata | input | 256 | Memory read data (full line) |

## Verification
The bench aims at the ordering gate under each of the three modes, with a non-empty buffer and UC, WC and ordinary requests:
- a gate decoded from the wrong mode bit lets an ordinary load overtake buffered stores;
- a gate that is too strict stalls UC traffic that should pass.

It overlaps a UC window with a WC window, so that an inverted priority shows up as a store merged instead of issued. It rewrites bytes that are already valid, changes line and fills a line completely; wrong byte masks, a lost overwrite or a missing self-drain all show up on `bus_be` or `bus_wdata`. The memory port stalls on a fixed pattern, so a drain that drops its data or clears the buffer before `bus_ready` is also caught.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

   typedef enum logic [1:0] {
      MT_ORD = 2'd0,
      MT_WC  = 2'd1,
      MT_UC  = 2'd2
   } wcc_mtype_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FLUSH = 1'b1
   } wcc_state_e;

endpackage

// File: rtl/wcc_range_file.sv
module wcc_range_file
   import wcc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_BITS  = 12,
   parameter int NUM_RANGES = 2,
   localparam int SEL_W     = $clog2(NUM_RANGES),
   localparam int PG_W      = ADDR_W - PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [PG_W-1:0]  cfg_base_pg,
   input  logic [PG_W-1:0]  cfg_mask_pg,
   input  logic             cfg_uc,
   input  logic             cfg_en,
   input  logic [PG_W-1:0]  look_pg,
   output wcc_mtype_e       look_type
);

   logic [NUM_RANGES-1:0] hit_uc;
   logic [NUM_RANGES-1:0] hit_wc;

   for (genvar i = 0; i < NUM_RANGES; i++) begin : g_win
      logic [PG_W-1:0] base_q;
      logic [PG_W-1:0] mask_q;
      logic            uc_q;
      logic            en_q;
      logic            hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            uc_q   <= 1'b0;
            en_q   <= 1'b0;
         end else if (cfg_we && cfg_sel == SEL_W'(i)) begin
            base_q <= cfg_base_pg;
            mask_q <= cfg_mask_pg;
            uc_q   <= cfg_uc;
            en_q   <= cfg_en;
         end
      end

      assign hit       = en_q && (((look_pg ^ base_q) & mask_q) == '0);
      assign hit_uc[i] = hit && uc_q;
      assign hit_wc[i] = hit && !uc_q;
   end

   always_comb begin
      if (|hit_uc)      look_type = MT_UC;
      else if (|hit_wc) look_type = MT_WC;
      else              look_type = MT_ORD;
   end

endmodule

// File: rtl/wcc_merge_buf.sv
module wcc_merge_buf #(
   parameter int LINE_BYTES  = 32,
   parameter int WORD_BYTES  = 4,
   parameter int LTAG_W      = 27,
   localparam int WORDS      = LINE_BYTES / WORD_BYTES,
   localparam int WI_W       = $clog2(WORDS),
   localparam int LINE_W     = LINE_BYTES * 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [LTAG_W-1:0]       wr_tag,
   input  logic [WI_W-1:0]         wr_word,
   input  logic [WORD_BYTES*8-1:0] wr_data,
   input  logic [WORD_BYTES-1:0]   wr_be,
   input  logic                    clr,
   output logic [LINE_W-1:0]       buf_data,
   output logic [LINE_BYTES-1:0]   buf_valid,
   output logic [LTAG_W-1:0]       buf_tag,
   output logic                    nonempty,
   output logic                    same_line,
   output logic                    fills
);

   logic [LINE_BYTES-1:0] hitv;

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
      localparam int W = b / WORD_BYTES;
      localparam int K = b % WORD_BYTES;
      logic       v_q;
      logic [7:0] d_q;

      assign hitv[b] = wr_en && (wr_word == WI_W'(W)) && wr_be[K];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       v_q <= 1'b0;
         else if (clr)     v_q <= 1'b0;
         else if (hitv[b]) v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hitv[b]) d_q <= wr_data[K*8 +: 8];
      end

      assign buf_valid[b]       = v_q;
      assign buf_data[b*8 +: 8] = d_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     buf_tag <= '0;
      else if (wr_en) buf_tag <= wr_tag;
   end

   assign nonempty  = |buf_valid;
   assign same_line = (buf_tag == wr_tag);
   assign fills     = &(buf_valid | hitv);

endmodule

// File: rtl/wc_range_ctrl.sv
module wc_range_ctrl
   import wcc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int PAGE_BITS  = 12,
   parameter int NUM_RANGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [$clog2(NUM_RANGES)-1:0] cfg_sel,
   input  logic [ADDR_W-1:PAGE_BITS]     cfg_base_pg,
   input  logic [ADDR_W-1:PAGE_BITS]     cfg_mask_pg,
   input  logic                          cfg_uc,
   input  logic                          cfg_en,
   input  logic [1:0]                    order_mode,
   input  logic                          flush_req,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [DATA_W-1:0]             req_wdata,
   input  logic [DATA_W/8-1:0]           req_be,
   output logic                          req_ready,
   output logic [DATA_W-1:0]             rsp_rdata,
   output logic                          bus_valid,
   output logic                          bus_write,
   output logic                          bus_burst,
   output logic [ADDR_W-1:0]             bus_addr,
   output logic [LINE_BYTES*8-1:0]       bus_wdata,
   output logic [LINE_BYTES-1:0]         bus_be,
   input  logic                          bus_ready,
   input  logic [LINE_BYTES*8-1:0]       bus_rdata
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int WORDS      = LINE_BYTES / WORD_BYTES;
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int WB_W       = $clog2(WORD_BYTES);
   localparam int WI_W       = OFF_W - WB_W;
   localparam int LTAG_W     = ADDR_W - OFF_W;
   localparam int LINE_W     = LINE_BYTES * 8;

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || WORD_BYTES < 2) begin : g_bad_data
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if ((1 << OFF_W) != LINE_BYTES || WORDS < 2) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding two or more words");
   end
   if (PAGE_BITS < OFF_W || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("PAGE_BITS must lie between the line offset and ADDR_W");
   end
   if (NUM_RANGES < 2) begin : g_bad_rng
      $error("NUM_RANGES must be at least 2");
   end

   wcc_state_e           state_q;
   wcc_mtype_e           cls;
   logic [WI_W-1:0]      word_idx;
   logic [LINE_W-1:0]    buf_data;
   logic [LINE_BYTES-1:0] buf_valid;
   logic [LTAG_W-1:0]    buf_tag;
   logic                 nonempty, same_line, fills;
   logic                 merge_en, go_flush, single, must_wait, clr;
   logic [LINE_BYTES-1:0] lane_be;

   assign word_idx = req_addr[OFF_W-1:WB_W];

   wcc_range_file #(
      .ADDR_W    (ADDR_W),
      .PAGE_BITS (PAGE_BITS),
      .NUM_RANGES(NUM_RANGES)
   ) u_ranges (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_base_pg(cfg_base_pg),
      .cfg_mask_pg(cfg_mask_pg),
      .cfg_uc     (cfg_uc),
      .cfg_en     (cfg_en),
      .look_pg    (req_addr[ADDR_W-1:PAGE_BITS]),
      .look_type  (cls)
   );

   wcc_merge_buf #(
      .LINE_BYTES(LINE_BYTES),
      .WORD_BYTES(WORD_BYTES),
      .LTAG_W    (LTAG_W)
   ) u_mbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (merge_en),
      .wr_tag   (req_addr[ADDR_W-1:OFF_W]),
      .wr_word  (word_idx),
      .wr_data  (req_wdata),
      .wr_be    (req_be),
      .clr      (clr),
      .buf_data (buf_data),
      .buf_valid(buf_valid),
      .buf_tag  (buf_tag),
      .nonempty (nonempty),
      .same_line(same_line),
      .fills    (fills)
   );

   // ordering gate: bit 1 lifts all ordering, bit 0 lets UC/WC cycles pass
   assign must_wait = nonempty && !order_mode[1] &&
                      (!order_mode[0] || cls == MT_ORD);

   always_comb begin
      merge_en = 1'b0;
      go_flush = 1'b0;
      single   = 1'b0;
      if (state_q == ST_IDLE) begin
         if (flush_req && nonempty) begin
            go_flush = 1'b1;
         end else if (req_valid) begin
            if (req_write && cls == MT_WC) begin
               if (!nonempty || same_line) merge_en = 1'b1;
               else                        go_flush = 1'b1;
            end else if (must_wait) begin
               go_flush = 1'b1;
            end else begin
               single = 1'b1;
            end
         end
      end
   end

   assign clr = (state_q == ST_FLUSH) && bus_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:  if (go_flush || (merge_en && fills)) state_q <= ST_FLUSH;
            ST_FLUSH: if (bus_ready)                       state_q <= ST_IDLE;
            default:                                       state_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_lane
      assign lane_be[w*WORD_BYTES +: WORD_BYTES] =
         (word_idx == WI_W'(w)) ? req_be : '0;
   end

   always_comb begin
      rsp_rdata = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (word_idx == WI_W'(w)) rsp_rdata = bus_rdata[w*DATA_W +: DATA_W];
      end
   end

   assign bus_burst = (state_q == ST_FLUSH);
   assign bus_valid = bus_burst || single;
   assign bus_write = bus_burst ? 1'b1 : req_write;
   assign bus_addr  = bus_burst ? {buf_tag, {OFF_W{1'b0}}} : req_addr;
   assign bus_wdata = bus_burst ? buf_data : {WORDS{req_wdata}};
   assign bus_be    = bus_burst ? buf_valid : lane_be;
   assign req_ready = merge_en || (single && bus_ready);

endmodule

// File: rtl/wcc_checker.sv
module wcc_checker
   import wcc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = LINE_BYTES * 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            order_mode,
   input logic                  req_valid,
   input logic                  req_write,
   input logic                  req_ready,
   input wcc_mtype_e            req_cls,
   input logic                  bus_valid,
   input logic                  bus_burst,
   input logic                  bus_ready,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [LINE_W-1:0]     bus_wdata,
   input logic [LINE_BYTES-1:0] bus_be,
   input logic [LINE_BYTES-1:0] buf_valid
);

   AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_burst |-> bus_addr[OFF_W-1:0] == '0 && bus_be != '0); // R5

   AST_BURST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_burst && !bus_ready |=>
         bus_valid && bus_burst && $stable(bus_addr) && $stable(bus_be) &&
         $stable(bus_wdata)); // R5

   AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_burst && bus_ready |=> buf_valid == '0); // R5

   AST_NO_ACCEPT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_burst |-> !req_ready); // R6

   AST_FULL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      &buf_valid |-> bus_valid && bus_burst); // R7

   AST_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !(req_write && req_cls == MT_WC) |=>
         $stable(buf_valid)); // R3

   AST_RELAXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_burst && order_mode == 2'b01 && req_cls == MT_ORD |->
         buf_valid == '0); // R10

   AST_STRICT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_burst && order_mode == 2'b00 |-> buf_valid == '0); // R11

endmodule

bind wc_range_ctrl wcc_checker #(
   .ADDR_W    (ADDR_W),
   .LINE_BYTES(LINE_BYTES)
) u_wcc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .order_mode(order_mode),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_ready (req_ready),
   .req_cls   (cls),
   .bus_valid (bus_valid),
   .bus_burst (bus_burst),
   .bus_ready (bus_ready),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_be    (bus_be),
   .buf_valid (buf_valid)
);

// File: tb/tb_wc_range_ctrl.sv
module tb_wc_range_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [0:0]   cfg_sel = '0;
   logic [31:12] cfg_base_pg = '0;
   logic [31:12] cfg_mask_pg = '0;
   logic         cfg_uc = 1'b0;
   logic         cfg_en = 1'b0;
   logic [1:0]   order_mode = 2'b10;
   logic         flush_req = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic [31:0]  req_addr = '0;
   logic [31:0]  req_wdata = '0;
   logic [3:0]   req_be = '0;
   logic         req_ready;
   logic [31:0]  rsp_rdata;
   logic         bus_valid, bus_write, bus_burst;
   logic [31:0]  bus_addr;
   logic [255:0] bus_wdata;
   logic [31:0]  bus_be;
   logic         bus_ready = 1'b1;
   logic [255:0] bus_rdata;

   int    checks = 0;
   int    fails = 0;
   int    cyc = 0;
   int    rcnt = 0;
   string ctx = "R1";

   // reference model state
   logic [7:0]  m_data [32];
   bit          m_val [32];
   logic [26:0] m_line = '0;
   bit          m_fl = 1'b0;
   logic [19:0] r_base [2];
   logic [19:0] r_mask [2];
   bit          r_uc [2];
   bit          r_en [2];

   wc_range_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_base_pg(cfg_base_pg), .cfg_mask_pg(cfg_mask_pg), .cfg_uc(cfg_uc),
      .cfg_en(cfg_en), .order_mode(order_mode), .flush_req(flush_req),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
      .rsp_rdata(rsp_rdata), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_burst(bus_burst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_be(bus_be), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", ctx, what, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   function automatic int classify(input logic [31:0] a);
      bit u = 1'b0;
      bit w = 1'b0;
      for (int i = 0; i < 2; i++) begin
         if (r_en[i] && (((a[31:12] ^ r_base[i]) & r_mask[i]) == 20'd0)) begin
            if (r_uc[i]) u = 1'b1;
            else         w = 1'b1;
         end
      end
      return u ? 2 : (w ? 1 : 0);
   endfunction

   task automatic model_step;
      logic [255:0] ewd = '0;
      logic [255:0] bmask = '0;
      logic [31:0]  ebe = '0;
      logic [31:0]  eaddr = '0;
      bit ebv = 0, eburst = 0, ewr = 0, erdy = 0;
      bit nonempty = 0, setfl = 0, merge = 0, clear = 0, full = 1;
      int cls, wi;
      for (int b = 0; b < 32; b++) if (m_val[b]) nonempty = 1;
      wi  = int'(req_addr[4:2]);
      cls = classify(req_addr);
      if (m_fl) begin
         ebv = 1; eburst = 1; ewr = 1; eaddr = {m_line, 5'b0};
         for (int b = 0; b < 32; b++) begin
            ewd[b*8 +: 8] = m_data[b];
            ebe[b] = m_val[b];
         end
         clear = bus_ready;
      end else if (flush_req && nonempty) begin
         setfl = 1;
      end else if (req_valid) begin
         if (req_write && cls == 1) begin
            if (!nonempty || m_line == req_addr[31:5]) begin
               erdy = 1; merge = 1;
            end else setfl = 1;
         end else if (nonempty && !order_mode[1] && (!order_mode[0] || cls == 0)) begin
            setfl = 1;
         end else begin
            ebv = 1; ewr = req_write; eaddr = req_addr;
            ewd = {8{req_wdata}};
            ebe = 32'(req_be) << (4 * wi);
            erdy = bus_ready;
         end
      end
      chk(req_ready === erdy, "req_ready", 256'(req_ready), 256'(erdy));
      chk(bus_valid === ebv, "bus_valid", 256'(bus_valid), 256'(ebv));
      if (ebv) begin
         chk(bus_burst === eburst, "bus_burst", 256'(bus_burst), 256'(eburst));
         chk(bus_write === ewr, "bus_write", 256'(bus_write), 256'(ewr));
         chk(bus_addr === eaddr, "bus_addr", 256'(bus_addr), 256'(eaddr));
         chk(bus_be === ebe, "bus_be", 256'(bus_be), 256'(ebe));
         if (ewr) begin
            for (int b = 0; b < 32; b++) if (ebe[b]) bmask[b*8 +: 8] = 8'hFF;
            chk((bus_wdata & bmask) === (ewd & bmask), "bus_wdata",
                bus_wdata & bmask, ewd & bmask);
         end
      end
      if (erdy && !req_write) begin
         chk(rsp_rdata === bus_rdata[wi*32 +: 32], "rsp_rdata",
             256'(rsp_rdata), 256'(bus_rdata[wi*32 +: 32]));
      end
      if (cfg_we) begin
         r_base[cfg_sel] = cfg_base_pg;
         r_mask[cfg_sel] = cfg_mask_pg;
         r_uc[cfg_sel]   = cfg_uc;
         r_en[cfg_sel]   = cfg_en;
      end
      if (clear) begin
         for (int b = 0; b < 32; b++) m_val[b] = 0;
         m_fl = 0;
      end
      if (setfl) m_fl = 1;
      if (merge) begin
         m_line = req_addr[31:5];
         for (int k = 0; k < 4; k++) begin
            if (req_be[k]) begin
               m_data[wi*4 + k] = req_wdata[k*8 +: 8];
               m_val[wi*4 + k]  = 1;
            end
         end
         for (int b = 0; b < 32; b++) if (!m_val[b]) full = 0;
         if (full) m_fl = 1;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) model_step();
   end

   always @(posedge clk) begin
      cyc++;
      rcnt++;
      #1 bus_ready = (rcnt % 3) != 1;
      if (cyc > WATCHDOG) begin
         chk(1'b0, "watchdog expired", 256'(cyc), 256'(WATCHDOG));
         report();
      end
   end

   task automatic do_req(input bit w, input logic [31:0] a,
                         input logic [31:0] d, input logic [3:0] be);
      @(posedge clk); #2;
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
      while (1) begin
         @(negedge clk);
         if (req_ready) break;
      end
      @(posedge clk); #2;
      req_valid = 0;
   endtask

   task automatic do_cfg(input bit sel, input logic [19:0] base,
                         input logic [19:0] mask, input bit uc, input bit en);
      @(posedge clk); #2;
      cfg_we = 1; cfg_sel = sel; cfg_base_pg = base; cfg_mask_pg = mask;
      cfg_uc = uc; cfg_en = en;
      @(posedge clk); #2;
      cfg_we = 0;
   endtask

   task automatic do_flush;
      @(posedge clk); #2;
      flush_req = 1;
      @(posedge clk); #2;
      flush_req = 0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      for (int w = 0; w < 8; w++) bus_rdata[w*32 +: 32] = 32'hC0DE_0000 + w * 32'h111;
      for (int b = 0; b < 32; b++) begin m_val[b] = 0; m_data[b] = '0; end
      for (int i = 0; i < 2; i++) begin
         r_base[i] = '0; r_mask[i] = '0; r_uc[i] = 0; r_en[i] = 0;
      end
      // R1: quiet outputs while in reset
      @(negedge clk); @(negedge clk);
      chk(bus_valid === 1'b0, "bus_valid in reset", 256'(bus_valid), 256'(0));
      chk(req_ready === 1'b0, "req_ready in reset", 256'(req_ready), 256'(0));
      @(posedge clk); #2 rst_n = 1;
      settle(2);
      // R1: unprogrammed windows make every address ordinary
      ctx = "R1";
      do_req(1, 32'h0001_0004, 32'h1111_2222, 4'hF);
      // R2: program a WC page and a UC 64 KiB region
      ctx = "R2";
      do_cfg(0, 20'h00010, 20'hFFFFF, 0, 1);
      do_cfg(1, 20'h00020, 20'hFFFF0, 1, 1);
      // R4: merging and byte overwrite (no ordering mode)
      ctx = "R4";
      do_req(1, 32'h0001_0000, 32'hA1A2A3A4, 4'hF);
      do_req(1, 32'h0001_0004, 32'hB1B2B3B4, 4'h3);
      do_req(1, 32'h0001_0000, 32'h000000EE, 4'h1);
      // R9: everything passes a non-empty buffer
      ctx = "R9";
      do_req(0, 32'h0001_0008, 32'h0, 4'hF);
      do_req(1, 32'h0003_0010, 32'h5555_6666, 4'hC);
      // R3: UC read, UC write, unaligned lane
      ctx = "R3";
      do_req(0, 32'h0002_0014, 32'h0, 4'hF);
      do_req(1, 32'h0002_001C, 32'h7777_8888, 4'h6);
      // R8: explicit drain, then a drain request on an empty buffer
      ctx = "R8";
      do_flush();
      settle(4);
      do_flush();
      settle(3);
      // R6: store to a different WC line
      ctx = "R6";
      do_req(1, 32'h0001_0000, 32'h0102_0304, 4'hF);
      do_req(1, 32'h0001_0024, 32'h0506_0708, 4'hF);
      do_flush();
      settle(4);
      // R7: fill one line completely
      ctx = "R7";
      for (int w = 0; w < 8; w++)
         do_req(1, 32'h0001_0040 + 32'(w * 4), 32'hF000_0000 + 32'(w), 4'hF);
      settle(5);
      // R10: relaxed ordering
      ctx = "R10";
      @(posedge clk); #2 order_mode = 2'b01;
      do_req(1, 32'h0001_0060, 32'h1234_5678, 4'hF);
      do_req(0, 32'h0002_0000, 32'h0, 4'hF);
      do_req(0, 32'h0001_0064, 32'h0, 4'hF);
      do_req(0, 32'h0003_0008, 32'h0, 4'hF);
      settle(3);
      // R11: strict ordering
      ctx = "R11";
      @(posedge clk); #2 order_mode = 2'b00;
      do_req(1, 32'h0001_0080, 32'h9ABC_DEF0, 4'h5);
      do_req(1, 32'h0002_0040, 32'h2468_ACE0, 4'hF);
      do_req(1, 32'h0001_0084, 32'h1357_9BDF, 4'hA);
      do_req(0, 32'h0001_0088, 32'h0, 4'hF);
      settle(3);
      // R2: overlapping windows, UC wins; then disable the WC window
      ctx = "R2";
      @(posedge clk); #2 order_mode = 2'b10;
      do_cfg(0, 20'h00020, 20'hFFFE0, 0, 1);
      do_req(1, 32'h0002_0004, 32'hCAFE_F00D, 4'hF);
      do_req(1, 32'h0003_0004, 32'hBEEF_0001, 4'hF);
      do_flush();
      settle(4);
      do_cfg(0, 20'h00010, 20'hFFFFF, 0, 0);
      do_req(1, 32'h0001_0000, 32'h0BAD_0BAD, 4'hF);
      settle(6);
      report();
   end

endmodule